// File: doc/BRIEF.md
# Card Presence Detect and Reset Sequencer

This block watches the two active-low card-detect pins of a removable-card socket and decides whether a card is fully seated. A card counts as seated only when both pins are low together. Each pin pattern must settle before it is trusted. The block keeps a registered presence flag and raises a one-cycle event whenever that flag changes.

On every insertion the block drives a card reset line for a fixed time. This time is set in microseconds and turned into clock cycles through a cycles-per-microsecond parameter. Software can also hold the same reset line through a request input. If the card is pulled out while the reset is still running, the reset ends at once.

A host-enable input gates the whole block. While it is low, the outputs sit idle and the detect filter is cleared. When it is raised again, detection starts over, so a card that is already seated is reported as a fresh insertion. All pins are plain control and status signals, with no data stream and no handshake.

Top module: `card_presence_seq`

## Requirements
- R1: A card is seated only when `cd_a_n`=0 and `cd_b_n`=0. The patterns 01, 10 and 11 all mean absent, and `present` stays or goes to 0.
- R2: A synchronized pin pattern must hold for STABLE_CYCLES consecutive cycles before presence follows it. A pattern that lasts fewer cycles changes neither `present` nor `detect_evt`.
- R3: Each change of `present` comes with exactly one single-cycle `detect_evt`, in the same cycle as the new `present` value. Repeated samples of an unchanged state produce no event.
- R4: When `present` rises, `card_rst` goes high in that same cycle and stays high for exactly CYC_PER_US*RST_US cycles, provided the card stays seated and software makes no request.
- R5: If `present` falls while the insertion reset is running, `card_rst` is low from that same cycle on, unless `sw_rst_req` is high.
- R6: While `host_en`=1, `sw_rst_req`=1 holds `card_rst` high in the same cycle.
- R7: While `host_en`=0, `card_rst` is 0 and `present` is 0 from the next cycle, and no event is raised. After `host_en` returns to 1 with a seated card, a new insertion event and a new reset pulse follow.
- R8: After reset, `present`, `detect_evt` and `card_rst` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cd_a_n | input | 1 | Raw first card-detect pin, low when contact is made |
| cd_b_n | input | 1 | Raw second card-detect pin, low when contact is made |
| host_en | input | 1 | Host enable; low forces idle outputs and clears detection |
| sw_rst_req | input | 1 | Software card reset request |
| present | output | 1 | Card seated flag |
| detect_evt | output | 1 | One-cycle pulse on each change of `present` |
| card_rst | output | 1 | Card reset line, active high |

## Verification
The bench drives each half-seated pin pattern. A design that accepted a single low pin would report a card that is only half inserted. It sends glitches shorter than the stability window in both directions; a design without the filter would raise spurious event pairs. It measures the insertion reset length exactly, so an off-by-one in the timer shows as a pulse one cycle too short or too long. It also pulls the card during that pulse, and a design that missed the abort would keep resetting an empty socket. Finally it drops and restores host enable with a card seated. A design that kept stale state would then miss the second insertion event or still drive the reset while disabled.

// File: rtl/cpd_pkg.sv
package cpd_pkg;
  typedef enum logic [1:0] {
    EV_NONE   = 2'd0,
    EV_INSERT = 2'd1,
    EV_REMOVE = 2'd2
  } cpd_evt_e;

  localparam int unsigned PIN_COUNT = 2;
endpackage

// File: rtl/cpd_sync.sv
module cpd_sync #(
  parameter int unsigned WIDTH  = 2,
  parameter int unsigned STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d_in,
  output logic [WIDTH-1:0] q_out
);
  // Pins idle high (no card) out of reset.
  logic [WIDTH-1:0] stage_q [STAGES];

  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) stage_q[s] <= '1;
          else        stage_q[s] <= d_in;
        end
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) stage_q[s] <= '1;
          else        stage_q[s] <= stage_q[s-1];
        end
      end
    end
  endgenerate

  assign q_out = stage_q[STAGES-1];
endmodule

// File: rtl/cpd_filter.sv
module cpd_filter #(
  parameter int unsigned STABLE_CYCLES = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic enable,
  input  logic sample,
  output logic stable
);
  localparam int unsigned CW = (STABLE_CYCLES > 1) ? $clog2(STABLE_CYCLES) : 1;
  localparam logic [CW-1:0] LAST = CW'(STABLE_CYCLES - 1);

  logic          cand_q;
  logic [CW-1:0] cnt_q;
  logic          stable_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cand_q   <= 1'b0;
      cnt_q    <= '0;
      stable_q <= 1'b0;
    end else if (!enable) begin
      cand_q   <= 1'b0;
      cnt_q    <= '0;
      stable_q <= 1'b0;
    end else if (sample != cand_q) begin
      cand_q <= sample;
      cnt_q  <= '0;
    end else if (cnt_q == LAST) begin
      stable_q <= cand_q;
    end else begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  assign stable = stable_q;
endmodule

// File: rtl/cpd_rst_timer.sv
module cpd_rst_timer #(
  parameter int unsigned CYCLES = 400
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clear,
  input  logic start,
  output logic busy
);
  localparam int unsigned CW = $clog2(CYCLES + 1);
  localparam logic [CW-1:0] LOAD = CW'(CYCLES);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              cnt_q <= '0;
    else if (clear)          cnt_q <= '0;
    else if (start)          cnt_q <= LOAD;
    else if (cnt_q != '0)    cnt_q <= cnt_q - 1'b1;
  end

  assign busy = (cnt_q != '0);
endmodule

// File: rtl/card_presence_seq.sv
module card_presence_seq #(
  parameter int unsigned SYNC_STAGES   = 2,
  parameter int unsigned STABLE_CYCLES = 4,
  parameter int unsigned CYC_PER_US    = 100,
  parameter int unsigned RST_US        = 200
) (
  input  logic clk,
  input  logic rst_n,
  input  logic cd_a_n,
  input  logic cd_b_n,
  input  logic host_en,
  input  logic sw_rst_req,
  output logic present,
  output logic detect_evt,
  output logic card_rst
);
  import cpd_pkg::*;

  localparam int unsigned RST_CYCLES = CYC_PER_US * RST_US;

  logic [PIN_COUNT-1:0] pins_s;
  logic                 seated_now;
  logic                 seated_stable;
  logic                 present_q;
  logic                 evt_q;
  logic                 pulse_busy;
  cpd_evt_e             evt_kind;

  cpd_sync #(.WIDTH(PIN_COUNT), .STAGES(SYNC_STAGES)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d_in  ({cd_b_n, cd_a_n}),
    .q_out (pins_s)
  );

  // Seated only when every detect pin reads low.
  assign seated_now = ~|pins_s;

  cpd_filter #(.STABLE_CYCLES(STABLE_CYCLES)) u_filter (
    .clk    (clk),
    .rst_n  (rst_n),
    .enable (host_en),
    .sample (seated_now),
    .stable (seated_stable)
  );

  always_comb begin
    evt_kind = EV_NONE;
    if (host_en && (seated_stable != present_q))
      evt_kind = seated_stable ? EV_INSERT : EV_REMOVE;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      present_q <= 1'b0;
      evt_q     <= 1'b0;
    end else if (!host_en) begin
      present_q <= 1'b0;
      evt_q     <= 1'b0;
    end else begin
      evt_q <= (evt_kind != EV_NONE);
      if (evt_kind != EV_NONE) present_q <= seated_stable;
    end
  end

  cpd_rst_timer #(.CYCLES(RST_CYCLES)) u_timer (
    .clk   (clk),
    .rst_n (rst_n),
    .clear (!host_en || (evt_kind == EV_REMOVE)),
    .start (evt_kind == EV_INSERT),
    .busy  (pulse_busy)
  );

  assign present    = present_q;
  assign detect_evt = evt_q;
  assign card_rst   = host_en & (pulse_busy | sw_rst_req);
endmodule

// File: rtl/cpd_checker.sv
module cpd_checker (
  input logic clk,
  input logic rst_n,
  input logic host_en,
  input logic sw_rst_req,
  input logic present,
  input logic detect_evt,
  input logic card_rst
);
  // R3
  evt_marks_change_chk: assert property (@(posedge clk) disable iff (!rst_n)
    detect_evt |-> (present != $past(present)));

  // R3
  evt_single_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    detect_evt |=> !detect_evt);

  // R4
  insert_starts_reset_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(present) |-> card_rst);

  // R5
  removal_aborts_reset_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(present) && !sw_rst_req) |-> !card_rst);

  // R7
  disabled_no_reset_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !host_en |-> !card_rst);

  // R7
  disabled_clears_presence_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !host_en |=> (!present && !detect_evt));
endmodule

bind card_presence_seq cpd_checker u_cpd_checker (
  .clk        (clk),
  .rst_n      (rst_n),
  .host_en    (host_en),
  .sw_rst_req (sw_rst_req),
  .present    (present),
  .detect_evt (detect_evt),
  .card_rst   (card_rst)
);

// File: tb/tb_card_presence_seq.sv
module tb_card_presence_seq;
  localparam int CLK_PERIOD = 10;
  localparam int STABLE     = 4;
  localparam int CPU        = 2;
  localparam int RUS        = 20;
  localparam int PULSE      = CPU * RUS;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cd_a_n = 1'b1, cd_b_n = 1'b1;
  logic host_en = 1'b0, sw_rst_req = 1'b0;
  logic present, detect_evt, card_rst;

  int checks = 0;
  int errors = 0;
  int pushed = 0;
  int seen = 0;
  bit exp_q[$];
  bit prev_evt = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  card_presence_seq #(
    .SYNC_STAGES(2), .STABLE_CYCLES(STABLE), .CYC_PER_US(CPU), .RST_US(RUS)
  ) dut (
    .clk(clk), .rst_n(rst_n), .cd_a_n(cd_a_n), .cd_b_n(cd_b_n),
    .host_en(host_en), .sw_rst_req(sw_rst_req),
    .present(present), .detect_evt(detect_evt), .card_rst(card_rst)
  );

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic summary();
    $display("  Result: errors=%0d of %0d checks", errors, checks);
  endtask

  task automatic cycles(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic expect_evt(input bit v);
    exp_q.push_back(v);
    pushed++;
  endtask

  task automatic wait_present(input bit v, input string tag);
    int n = 0;
    while (present !== v && n < 100) begin
      @(negedge clk);
      n++;
    end
    check(present === v, tag, present, v);
  endtask

  // Scoreboard monitor: each event is compared against the queued expectation (R3).
  always @(negedge clk) begin
    if (rst_n) begin
      if (detect_evt === 1'b1) begin
        seen++;
        if (exp_q.size() == 0) begin
          check(1'b0, "R3 unexpected event", present, -1);
        end else begin
          bit e;
          e = exp_q.pop_front();
          check(present === e, "R3 event direction", present, e);
        end
        check(prev_evt == 1'b0, "R3 event lasts one cycle", 2, 1);
      end
      prev_evt = (detect_evt === 1'b1);
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    check(1'b0, "watchdog", 0, 1);
    summary();
    $finish;
  end

  initial begin
    int len;
    cycles(3);
    // R8 reset state
    check(present === 1'b0, "R8 present", present, 0);
    check(detect_evt === 1'b0, "R8 detect_evt", detect_evt, 0);
    check(card_rst === 1'b0, "R8 card_rst", card_rst, 0);
    rst_n = 1'b1;
    host_en = 1'b1;
    cycles(20);
    check(present === 1'b0, "R1 pins 11 absent", present, 0);

    // R1 half-seated patterns
    cd_a_n = 1'b0; cd_b_n = 1'b1; cycles(20);
    check(present === 1'b0, "R1 pins a=0 b=1 absent", present, 0);
    cd_a_n = 1'b1; cd_b_n = 1'b0; cycles(20);
    check(present === 1'b0, "R1 pins a=1 b=0 absent", present, 0);
    cd_b_n = 1'b1; cycles(10);

    // R2 short glitch toward seated
    cd_a_n = 1'b0; cd_b_n = 1'b0; cycles(STABLE - 2);
    cd_a_n = 1'b1; cd_b_n = 1'b1; cycles(20);
    check(present === 1'b0, "R2 short seated glitch ignored", present, 0);

    // R1/R4 insertion and exact pulse length
    expect_evt(1'b1);
    cd_a_n = 1'b0; cd_b_n = 1'b0;
    wait_present(1'b1, "R1 both low seated");
    len = 0;
    while (card_rst === 1'b1 && len < PULSE + 10) begin
      len++;
      @(negedge clk);
    end
    check(len == PULSE, "R4 reset pulse length", len, PULSE);
    cycles(10);

    // R2 short glitch toward absent
    cd_a_n = 1'b1; cycles(STABLE - 2);
    cd_a_n = 1'b0; cycles(20);
    check(present === 1'b1, "R2 short removal glitch ignored", present, 1);
    check(card_rst === 1'b0, "R3 no new pulse without change", card_rst, 0);

    // R6 software reset request
    sw_rst_req = 1'b1; #1;
    check(card_rst === 1'b1, "R6 software reset asserts line", card_rst, 1);
    cycles(3);
    sw_rst_req = 1'b0; #1;
    check(card_rst === 1'b0, "R6 software reset release", card_rst, 0);

    // R5 removal aborts a running pulse
    expect_evt(1'b0);
    cd_a_n = 1'b1; cd_b_n = 1'b1;
    wait_present(1'b0, "R1 removal detected");
    expect_evt(1'b1);
    cd_a_n = 1'b0; cd_b_n = 1'b0;
    wait_present(1'b1, "R4 reinsertion detected");
    cycles(5);
    check(card_rst === 1'b1, "R4 pulse running", card_rst, 1);
    expect_evt(1'b0);
    cd_a_n = 1'b1;
    wait_present(1'b0, "R5 removal during pulse");
    check(card_rst === 1'b0, "R5 pulse aborted on removal", card_rst, 0);
    cycles(5);
    check(card_rst === 1'b0, "R5 pulse stays off", card_rst, 0);

    // R7 host enable drop and restore with a seated card
    expect_evt(1'b1);
    cd_a_n = 1'b0;
    wait_present(1'b1, "R7 card seated before disable");
    cycles(PULSE + 5);
    host_en = 1'b0;
    sw_rst_req = 1'b1;
    cycles(3);
    check(present === 1'b0, "R7 disabled presence cleared", present, 0);
    check(card_rst === 1'b0, "R7 disabled reset idle", card_rst, 0);
    sw_rst_req = 1'b0;
    expect_evt(1'b1);
    host_en = 1'b1;
    wait_present(1'b1, "R7 re-enable reports insertion");
    check(card_rst === 1'b1, "R7 re-enable starts pulse", card_rst, 1);
    cycles(PULSE + 10);

    check(exp_q.size() == 0, "R3 all expected events seen", exp_q.size(), 0);
    check(seen == pushed, "R3 event count", seen, pushed);
    summary();
    $finish;
  end
endmodule